// File: doc/BRIEF.md
# SPI Command-Frame Transmitter

This block sends a short, write-only SPI frame of one to four bytes taken straight from a 32-bit command word, with no FIFO in the path. A 2-bit count field selects how many of the low-order bytes are valid. The frame starts on a transmit-start pulse, but only while command mode is on. The bytes go out most significant bit first, and the most significant of the valid bytes leads. The serial clock idles at a selectable level. Its half-period is set by a divider input. An optional gap of whole half-periods can follow the last bit before completion is signalled.

Completion sets a frame-end flag at bit 10 of a write-one-to-clear status word. An interrupt line follows that flag when the interrupt enable is high. The busy indication plays the role of the transmit-enable bit: it drops by itself when the frame is over, and a start pulse that arrives while it is high is not taken. The block has no receive path. The serial clock and the data line are registered outputs.

Top module: `cmd_frame_tx`

## Requirements
- R1: During and after reset, tx_busy, status, irq and mosi are 0 and sclk equals sclk_idle.
- R2: A frame starts only on a clock edge where tx_start and cmd_mode are both 1 and tx_busy is 0. A start while busy, or with cmd_mode at 0, changes neither the frame in flight nor sclk.
- R3: A byte_cnt value of n produces exactly 8*(n+1) leading sclk edges per frame.
- R4: The bits sent are cmd_word[8*(n+1)-1] down to cmd_word[0], in that order, one bit per leading edge. The upper bytes are never sent.
- R5: Every sclk half-period during a frame lasts clk_div+1 clock cycles, and this includes the first half-period after the start edge.
- R6: During a frame, mosi changes only on a trailing sclk edge (sclk returning to sclk_idle), apart from the load at the start edge. On a leading edge (sclk leaving sclk_idle) mosi holds the bit sent.
- R7: While no frame runs, sclk follows sclk_idle with one cycle of delay. The last trailing edge returns sclk to sclk_idle.
- R8: tx_busy clears by itself in the cycle where frame end is flagged.
- R9: Frame end sets status bit 10, and no other status bit. With gap_len = 0 it is set on the same edge as the last trailing edge. With gap_len = k it is set k*(clk_div+1) cycles later.
- R10: On each edge, irq is loaded with the next value of status bit 10 ANDed with irq_en.
- R11: A write with sts_wr clears every status bit whose sts_wdata bit is 1. Writing all ones clears the whole word, and a write with bit 10 at 0 leaves the frame-end flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_word | input | 32 | Command bytes, right-aligned |
| byte_cnt | input | 2 | Number of bytes minus one |
| cmd_mode | input | 1 | Enables the command path |
| tx_start | input | 1 | Start pulse (write of the command-transmit enable) |
| clk_div | input | 8 | Half-period length minus one, in clock cycles |
| sclk_idle | input | 1 | Idle level of sclk |
| gap_len | input | 4 | Trailing gap in half-periods, 0 for none |
| irq_en | input | 1 | Frame-end interrupt enable |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 16 | Write-one-to-clear mask |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| tx_busy | output | 1 | Frame in progress (self-clearing transmit enable) |
| status | output | 16 | Status word, bit 10 is frame end |
| irq | output | 1 | Frame-end interrupt |

## Verification
The hardest case to reach is a start pulse that lands while a frame is partway through. To produce it, the bench starts a two-byte frame at a slow divider. A few cycles later it changes cmd_word and byte_cnt and pulses tx_start again. The scoreboard still holds only the original bits, so any reload or restart appears as a bit-order or bit-count mismatch. The trailing gap is timed from the last sclk return to the rise of the flag, using a non-zero divider, so that a gap counted in clock cycles rather than half-periods is caught.

// File: rtl/cft_pkg.sv
package cft_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } cft_state_e;

  localparam int FE_BIT = 10;
endpackage

// File: rtl/cft_halfper.sv
module cft_halfper #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cft_shifter.sv
module cft_shifter #(
  parameter int BC_W = 2,
  localparam int CMD_W = 8 << BC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BC_W-1:0]  nbytes_m1,
  input  logic [CMD_W-1:0] word,
  input  logic             shift,
  output logic             out_bit
);
  logic [CMD_W-1:0] sh_q;
  logic [BC_W+2:0]  amt;

  // move the first valid byte to the top of the shifter
  assign amt     = {~nbytes_m1, 3'b000};
  assign out_bit = sh_q[CMD_W-1];

  always_ff @(posedge clk) begin
    if (rst)        sh_q <= '0;
    else if (load)  sh_q <= word << amt;
    else if (shift) sh_q <= {sh_q[CMD_W-2:0], 1'b0};
  end
endmodule

// File: rtl/cft_status.sv
module cft_status #(
  parameter int STS_W = 16,
  parameter int FE    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fe_set,
  input  logic             wr,
  input  logic [STS_W-1:0] wdata,
  input  logic             irq_en,
  output logic [STS_W-1:0] status,
  output logic             irq
);
  logic [STS_W-1:0] st_q, st_next, set_vec, clr_vec;

  always_comb begin
    set_vec     = '0;
    set_vec[FE] = fe_set;
    clr_vec     = wr ? wdata : '0;
    st_next     = (st_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      irq  <= 1'b0;
    end else begin
      st_q <= st_next;
      irq  <= st_next[FE] & irq_en;
    end
  end

  assign status = st_q;
endmodule

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx #(
  parameter int BC_W  = 2,
  parameter int DIV_W = 8,
  parameter int DLY_W = 4,
  parameter int STS_W = 16,
  localparam int CMD_W = 8 << BC_W,
  localparam int BL_W  = BC_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic [BC_W-1:0]  byte_cnt,
  input  logic             cmd_mode,
  input  logic             tx_start,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             sclk_idle,
  input  logic [DLY_W-1:0] gap_len,
  input  logic             irq_en,
  input  logic             sts_wr,
  input  logic [STS_W-1:0] sts_wdata,
  output logic             sclk,
  output logic             mosi,
  output logic             tx_busy,
  output logic [STS_W-1:0] status,
  output logic             irq
);
  import cft_pkg::*;

  cft_state_e       state_q;
  logic [BL_W-1:0]  bits_left_q;
  logic [DLY_W-1:0] gcnt_q;
  logic             sclk_q;
  logic             tick, accept, trailing, last_bit, shift, done;

  assign accept   = (state_q == ST_IDLE) && tx_start && cmd_mode;
  assign trailing = (state_q == ST_SHIFT) && tick && (sclk_q != sclk_idle);
  assign last_bit = (bits_left_q == BL_W'(1));
  assign shift    = trailing && !last_bit;
  assign done     = (trailing && last_bit && (gap_len == '0)) ||
                    ((state_q == ST_GAP) && tick && (gcnt_q == gap_len - 1'b1));

  cft_halfper #(.DIV_W(DIV_W)) u_hp (
    .clk (clk),
    .rst (rst),
    .run (state_q != ST_IDLE),
    .div (clk_div),
    .tick(tick)
  );

  cft_shifter #(.BC_W(BC_W)) u_sh (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .nbytes_m1(byte_cnt),
    .word     (cmd_word),
    .shift    (shift),
    .out_bit  (mosi)
  );

  cft_status #(.STS_W(STS_W), .FE(FE_BIT)) u_st (
    .clk   (clk),
    .rst   (rst),
    .fe_set(done),
    .wr    (sts_wr),
    .wdata (sts_wdata),
    .irq_en(irq_en),
    .status(status),
    .irq   (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      bits_left_q <= '0;
      gcnt_q      <= '0;
      sclk_q      <= sclk_idle;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          sclk_q <= sclk_idle;
          if (accept) begin
            state_q     <= ST_SHIFT;
            bits_left_q <= (BL_W'(byte_cnt) + BL_W'(1)) << 3;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (sclk_q == sclk_idle) begin
              sclk_q <= ~sclk_idle;
            end else begin
              sclk_q <= sclk_idle;
              if (last_bit) begin
                if (gap_len == '0) begin
                  state_q <= ST_IDLE;
                end else begin
                  state_q <= ST_GAP;
                  gcnt_q  <= '0;
                end
              end else begin
                bits_left_q <= bits_left_q - 1'b1;
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (done) state_q <= ST_IDLE;
            else      gcnt_q  <= gcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk    = sclk_q;
  assign tx_busy = (state_q != ST_IDLE);
endmodule

// File: rtl/cft_checker.sv
module cft_checker (
  input logic clk,
  input logic rst,
  input logic tx_start,
  input logic cmd_mode,
  input logic sclk_idle,
  input logic irq_en,
  input logic sts_wr,
  input logic sts_wfe,
  input logic sclk,
  input logic mosi,
  input logic tx_busy,
  input logic fe,
  input logic irq
);
  // R2: a frame only begins from an accepted start
  p_start_gate_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> $past(tx_start && cmd_mode));

  // R6: data moves only when sclk falls back to idle
  p_mosi_drive_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && $past(tx_busy) && (mosi != $past(mosi)))
      |-> (sclk == sclk_idle && $past(sclk) != sclk_idle));

  // R7: idle clock follows the idle level
  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!tx_busy && $past(!tx_busy)) |-> (sclk == $past(sclk_idle)));

  // R8: busy ends exactly when the flag rises
  p_busy_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(fe) |-> (!tx_busy && $past(tx_busy)));

  // R10: interrupt needs the flag and the enable
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (fe && $past(irq_en)));

  // R11: a clearing write while idle removes the flag
  p_w1c_r11: assert property (@(posedge clk) disable iff (rst)
    $past(sts_wr && sts_wfe && !tx_busy) |-> !fe);
endmodule

bind cmd_frame_tx cft_checker u_cft_checker (
  .clk      (clk),
  .rst      (rst),
  .tx_start (tx_start),
  .cmd_mode (cmd_mode),
  .sclk_idle(sclk_idle),
  .irq_en   (irq_en),
  .sts_wr   (sts_wr),
  .sts_wfe  (sts_wdata[cft_pkg::FE_BIT]),
  .sclk     (sclk),
  .mosi     (mosi),
  .tx_busy  (tx_busy),
  .fe       (status[cft_pkg::FE_BIT]),
  .irq      (irq)
);

// File: tb/tb_cmd_frame_tx.sv
module tb_cmd_frame_tx;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] cmd_word;
  logic [1:0]  byte_cnt;
  logic        cmd_mode, tx_start, sclk_idle, irq_en, sts_wr;
  logic [7:0]  clk_div;
  logic [3:0]  gap_len;
  logic [15:0] sts_wdata;
  logic        sclk, mosi, tx_busy, irq;
  logic [15:0] status;

  always #5 clk = ~clk;

  cmd_frame_tx dut (
    .clk(clk), .rst(rst), .cmd_word(cmd_word), .byte_cnt(byte_cnt),
    .cmd_mode(cmd_mode), .tx_start(tx_start), .clk_div(clk_div),
    .sclk_idle(sclk_idle), .gap_len(gap_len), .irq_en(irq_en),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sclk(sclk), .mosi(mosi),
    .tx_busy(tx_busy), .status(status), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_gap = 0;
  bit exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: pops expected bits on each leading edge
  logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_busy = 1'b0, prev_fe = 1'b0;
  int   hp_cnt = 0;
  int   last_chg = 0;
  always @(negedge clk) begin
    if (!rst) begin
      hp_cnt++;
      if (sclk != prev_sclk && (tx_busy || prev_busy)) begin
        chk(hp_cnt == int'(clk_div) + 1, "R5 half-period", hp_cnt, int'(clk_div) + 1);
        hp_cnt   = 0;
        last_chg = cyc;
        if (sclk != sclk_idle) begin
          if (exp_q.size() == 0) chk(1'b0, "R3 extra bit", 1, 0);
          else begin
            bit e;
            e = exp_q.pop_front();
            chk(mosi == e, "R4 bit order", mosi, e);
          end
        end
      end
      if (tx_busy && !prev_busy) hp_cnt = 0;
      if (tx_busy && prev_busy && mosi != prev_mosi)
        chk(sclk == sclk_idle && prev_sclk != sclk_idle, "R6 mosi edge", sclk, sclk_idle);
      if (status[10] && !prev_fe) begin
        chk(exp_q.size() == 0, "R3 bit count", exp_q.size(), 0);
        chk(!tx_busy, "R8 busy cleared", tx_busy, 0);
        chk(sclk == sclk_idle, "R7 sclk idle at end", sclk, sclk_idle);
        chk(cyc - last_chg == exp_gap, "R9 gap timing", cyc - last_chg, exp_gap);
        chk(status == 16'h0400, "R9 status word", status, 16'h0400);
      end
      prev_sclk = sclk;
      prev_mosi = mosi;
      prev_busy = tx_busy;
      prev_fe   = status[10];
    end
  end

  // driver: pushes the expected bits and runs one frame
  task automatic send(input logic [31:0] w, input logic [1:0] n, input logic [7:0] dv,
                      input logic [3:0] dly, input logic idl, input logic en,
                      input logic [15:0] clr, input bit poke);
    int t;
    clk_div   = dv;
    gap_len   = dly;
    sclk_idle = idl;
    irq_en    = en;
    cmd_word  = w;
    byte_cnt  = n;
    cmd_mode  = 1'b1;
    exp_gap   = int'(dly) * (int'(dv) + 1);
    repeat (3) @(negedge clk);
    chk(sclk == idl, "R7 idle level", sclk, idl);
    for (int i = 8 * (int'(n) + 1) - 1; i >= 0; i--) exp_q.push_back(w[i]);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      cmd_word = ~w;
      byte_cnt = 2'd3;
      tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      cmd_word = w;
    end
    t = 0;
    while (!status[10] && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(status[10], "R9 frame end seen", status[10], 1);
    chk(irq == en, "R10 irq follows enable", irq, en);
    @(negedge clk);
    sts_wr    = 1'b1;
    sts_wdata = 16'hFBFF;
    @(negedge clk);
    sts_wr = 1'b0;
    chk(status[10], "R11 write without bit 10 keeps flag", status[10], 1);
    chk(!tx_busy, "R2 poke not latched", tx_busy, 0);
    sts_wr    = 1'b1;
    sts_wdata = clr;
    @(negedge clk);
    sts_wr = 1'b0;
    chk(status == 16'h0000, "R11 cleared", status, 0);
    chk(irq == 1'b0, "R10 irq drops with flag", irq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_word = '0; byte_cnt = '0; cmd_mode = 1'b0; tx_start = 1'b0;
    sclk_idle = 1'b0; irq_en = 1'b0; sts_wr = 1'b0; sts_wdata = '0;
    clk_div = 8'd1; gap_len = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!tx_busy, "R1 busy", tx_busy, 0);
    chk(status == 16'h0, "R1 status", status, 0);
    chk(!irq, "R1 irq", irq, 0);
    chk(!mosi, "R1 mosi", mosi, 0);
    chk(sclk == sclk_idle, "R1 sclk", sclk, sclk_idle);

    // R3 R4 one byte, upper bytes junk, fastest clock
    send(32'hDEADBEA5, 2'd0, 8'd0, 4'd0, 1'b0, 1'b1, 16'h0400, 1'b0);
    // two bytes, idle high, R9 gap
    send(32'h1234C3E7, 2'd1, 8'd2, 4'd2, 1'b1, 1'b0, 16'hFFFF, 1'b0);
    // three bytes
    send(32'hFF5A0F81, 2'd2, 8'd1, 4'd0, 1'b0, 1'b1, 16'hFFFF, 1'b0);
    // four bytes with gap
    send(32'h96C35AF0, 2'd3, 8'd3, 4'd1, 1'b1, 1'b1, 16'h0400, 1'b0);
    // R2 start while busy is ignored
    send(32'h0000B2D4, 2'd1, 8'd3, 4'd0, 1'b0, 1'b1, 16'hFFFF, 1'b1);

    // R2 start without command mode
    cmd_mode = 1'b0;
    cmd_word = 32'hFFFFFFFF;
    byte_cnt = 2'd3;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    repeat (10) @(negedge clk);
    chk(!tx_busy, "R2 no start without cmd mode", tx_busy, 0);
    chk(sclk == sclk_idle, "R2 sclk untouched", sclk, sclk_idle);
    chk(status == 16'h0, "R2 no frame end", status, 0);

    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule